// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Interface

This block is the bit-level slave side of a single-wire, open-drain serial bus. The bus line idles high through a pull-up. The master starts every exchange by holding the line low. The block samples the line through a synchronizer and measures each low period. A long low period counts as a bus reset: the block raises a one-cycle strobe and then answers with a presence pulse of its own. A short low period marks a bit slot. The block either samples the line, which delivers a received bit, or holds the line low to send a 0 that an upper layer has supplied.

There are two speeds, and the speed only changes the timer values. The upper layer selects fast speed with a one-cycle strobe. In fast speed, a reset of moderate length keeps fast speed. A reset at least as long as the normal-speed minimum always returns the block to normal speed. Every time value is given in microseconds and scaled by a ticks-per-microsecond parameter. The values below are the defaults.

Top module: `swire_slave_bit`

## Requirements
- R1: After reset, bus_pd_n is 1, rx_valid, rst_det and tx_take are 0, and the block runs at normal speed.
- R2: At normal speed, a low period of at least 480 µs raises rst_det for exactly one cycle, starting at the third rising clock edge after the line returns high.
- R3: At normal speed, a low period shorter than 480 µs never raises rst_det and causes no presence pulse.
- R4: Presence pulse timing is counted from the edge that raised rst_det. bus_pd_n goes low at edge gap+1 and stays low for the low time, in cycles. Gap and low are 30 and 120 µs at normal speed, and 3 and 12 µs at fast speed. The speed used is the speed that holds after the reset.
- R5: If fast_go is high at a rising clock edge and no reset is decided at that edge, the block switches to fast speed.
- R6: At fast speed, a low period of at least 48 µs and shorter than 480 µs is a reset. The reset is followed by a fast presence pulse, and the block stays at fast speed.
- R7: A low period of at least 480 µs is a reset at either speed and returns the block to normal speed. The presence pulse and the following slots then use normal timing.
- R8: A slot starts at the third rising edge after the line falls. If tx_en is 0 at that edge, rx_valid is high for one cycle after edge 3+T. rx_bit is the line level at edge T+1, where 1 means the line was high. T is 30 µs at normal speed.
- R9: If tx_en is 1 at the slot start edge, tx_take is high for one cycle after that edge and rx_valid stays 0. If tx_bit is 0, bus_pd_n is low for T cycles from that edge. If tx_bit is 1, bus_pd_n stays 1.
- R10: A slot uses the speed that holds when the slot starts. At fast speed, T is 3 µs.
- R11: Line edges start no slot while a presence pulse is in progress. This period runs from rst_det until the line has settled high after the pulse. During it there is no tx_take and no rx_valid.
- R12: At fast speed, a low period shorter than 48 µs is a slot and not a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Raw bus line level |
| bus_pd_n | output | 1 | Active-low pull-down request for the open-drain driver |
| fast_go | input | 1 | One-cycle strobe that selects fast speed |
| tx_en | input | 1 | Next slot is a read slot |
| tx_bit | input | 1 | Bit to send in the next read slot |
| tx_take | output | 1 | One-cycle strobe when the pending bit is latched |
| rx_valid | output | 1 | One-cycle strobe with a received bit |
| rx_bit | output | 1 | Received bit value |
| rst_det | output | 1 | One-cycle strobe when a bus reset is recognized |

## Verification
A wrong speed flag is not visible until the next timed event. It then shows as a presence pulse or a slot sample point whose cycle count is off by a factor of ten. The bench measures every such event to the exact cycle, so a wrong flag is found at the first slot or reset after it goes wrong. A low-period counter that saturates early or starts at the wrong value shifts the reset decision at the 480 µs and 48 µs thresholds. The sweeps place pulses one tick on each side of those thresholds, so this shows as a missing or extra rst_det within three cycles of the line rising. A slot engine stuck in a waiting state shows as a missing rx_valid at the next slot.

// File: rtl/swire_pkg.sv
package swire_pkg;

  typedef enum logic [1:0] {
    SL_IDLE,
    SL_TIMED,
    SL_WAIT_HIGH
  } slot_state_t;

  typedef enum logic [1:0] {
    PR_IDLE,
    PR_GAP,
    PR_LOW,
    PR_REL
  } pres_state_t;

endpackage

// File: rtl/swire_line_sync.sv
module swire_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_in,
  output logic line_q,
  output logic fall,
  output logic rise,
  output logic settled_high
);

  logic [STAGES-1:0] sync_r;
  logic              line_d;

  // bus idles high, so the chain resets to 1
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_r <= '1;
      line_d <= 1'b1;
    end else begin
      sync_r <= {sync_r[STAGES-2:0], bus_in};
      line_d <= sync_r[STAGES-1];
    end
  end

  assign line_q       = sync_r[STAGES-1];
  assign fall         = line_d & ~line_q;
  assign rise         = ~line_d & line_q;
  assign settled_high = line_d & line_q;

endmodule

// File: rtl/swire_reset_det.sv
module swire_reset_det #(
  parameter int CW     = 16,
  parameter int T_LONG = 960,
  parameter int T_FAST = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic line_q,
  input  logic fall,
  input  logic rise,
  input  logic ignore,
  input  logic fast_go,
  output logic rst_det,
  output logic fast_mode
);

  logic [CW-1:0] low_cnt;
  logic          judge;
  logic          is_long;
  logic          is_fast_rst;

  // low-time counter, saturating at the long threshold
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
    end else if (fall) begin
      low_cnt <= CW'(1);
    end else if (!line_q && low_cnt != CW'(T_LONG)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign judge       = rise && !ignore;
  assign is_long     = judge && (low_cnt >= CW'(T_LONG));
  assign is_fast_rst = judge && fast_mode && (low_cnt >= CW'(T_FAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_det   <= 1'b0;
      fast_mode <= 1'b0;
    end else begin
      rst_det <= is_long || is_fast_rst;
      if (is_long) begin
        fast_mode <= 1'b0;
      end else if (fast_go) begin
        fast_mode <= 1'b1;
      end
    end
  end

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rst_det |=> !rst_det); // R2

  AST_SHORT_NO_RST: assert property (@(posedge clk) disable iff (rst)
    (rise && !fast_mode && low_cnt < CW'(T_LONG)) |=> !rst_det); // R3

  AST_LONG_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (rise && !ignore && low_cnt >= CW'(T_LONG)) |=> (rst_det && !fast_mode)); // R7

endmodule

// File: rtl/swire_presence.sv
module swire_presence
  import swire_pkg::*;
#(
  parameter int CW       = 16,
  parameter int T_GAP_N  = 60,
  parameter int T_GAP_F  = 6,
  parameter int T_LOW_N  = 240,
  parameter int T_LOW_F  = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic fast_mode,
  input  logic settled_high,
  output logic pd_n,
  output logic busy
);

  pres_state_t   st;
  logic [CW-1:0] cnt;
  logic          fast_q;
  logic [CW-1:0] gap_t;
  logic [CW-1:0] low_t;

  assign gap_t = fast_q ? CW'(T_GAP_F) : CW'(T_GAP_N);
  assign low_t = fast_q ? CW'(T_LOW_F) : CW'(T_LOW_N);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PR_IDLE;
      cnt    <= '0;
      fast_q <= 1'b0;
      pd_n   <= 1'b1;
    end else begin
      case (st)
        PR_IDLE: begin
          if (start) begin
            st     <= PR_GAP;
            cnt    <= CW'(1);
            fast_q <= fast_mode;
          end
        end
        PR_GAP: begin
          if (cnt == gap_t) begin
            st   <= PR_LOW;
            cnt  <= CW'(1);
            pd_n <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PR_LOW: begin
          if (cnt == low_t) begin
            st   <= PR_REL;
            pd_n <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PR_REL: begin
          // hold off until the line has settled high again
          if (settled_high) st <= PR_IDLE;
        end
        default: st <= PR_IDLE;
      endcase
    end
  end

  assign busy = (st != PR_IDLE);

  AST_PRES_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && pd_n)); // R4

endmodule

// File: rtl/swire_slot.sv
module swire_slot
  import swire_pkg::*;
#(
  parameter int CW       = 16,
  parameter int T_SLOT_N = 60,
  parameter int T_SLOT_F = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic line_q,
  input  logic fall,
  input  logic block,
  input  logic fast_mode,
  input  logic tx_en,
  input  logic tx_bit,
  output logic pd_n,
  output logic rx_valid,
  output logic rx_data,
  output logic tx_take
);

  slot_state_t   st;
  logic [CW-1:0] cnt;
  logic          fast_q;
  logic          read_q;
  logic [CW-1:0] tim_t;

  assign tim_t = fast_q ? CW'(T_SLOT_F) : CW'(T_SLOT_N);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SL_IDLE;
      cnt      <= '0;
      fast_q   <= 1'b0;
      read_q   <= 1'b0;
      pd_n     <= 1'b1;
      rx_valid <= 1'b0;
      rx_data  <= 1'b0;
      tx_take  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_take  <= 1'b0;
      case (st)
        SL_IDLE: begin
          if (fall && !block) begin
            st      <= SL_TIMED;
            cnt     <= CW'(1);
            fast_q  <= fast_mode;
            read_q  <= tx_en;
            tx_take <= tx_en;
            pd_n    <= !(tx_en && !tx_bit);
          end
        end
        SL_TIMED: begin
          if (cnt == tim_t) begin
            st   <= SL_WAIT_HIGH;
            pd_n <= 1'b1;
            if (!read_q) begin
              rx_valid <= 1'b1;
              rx_data  <= line_q;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SL_WAIT_HIGH: begin
          if (line_q) st <= SL_IDLE;
        end
        default: st <= SL_IDLE;
      endcase
    end
  end

  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R8

  AST_READ_NO_RX: assert property (@(posedge clk) disable iff (rst)
    (st == SL_TIMED && read_q) |=> !rx_valid); // R9

  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tx_take |=> !tx_take); // R9

endmodule

// File: rtl/swire_slave_bit.sv
module swire_slave_bit #(
  parameter int TICKS_PER_US     = 100,
  parameter int SYNC_STAGES      = 2,
  parameter int RST_LONG_US      = 480,
  parameter int RST_FAST_US      = 48,
  parameter int PRES_GAP_US      = 30,
  parameter int PRES_GAP_FAST_US = 3,
  parameter int PRES_LOW_US      = 120,
  parameter int PRES_LOW_FAST_US = 12,
  parameter int SLOT_US          = 30,
  parameter int SLOT_FAST_US     = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_in,
  output logic bus_pd_n,
  input  logic fast_go,
  input  logic tx_en,
  input  logic tx_bit,
  output logic tx_take,
  output logic rx_valid,
  output logic rx_bit,
  output logic rst_det
);

  localparam int T_RST_LONG  = RST_LONG_US * TICKS_PER_US;
  localparam int T_RST_FAST  = RST_FAST_US * TICKS_PER_US;
  localparam int T_GAP_N     = PRES_GAP_US * TICKS_PER_US;
  localparam int T_GAP_F     = PRES_GAP_FAST_US * TICKS_PER_US;
  localparam int T_LOW_N     = PRES_LOW_US * TICKS_PER_US;
  localparam int T_LOW_F     = PRES_LOW_FAST_US * TICKS_PER_US;
  localparam int T_SLOT_N    = SLOT_US * TICKS_PER_US;
  localparam int T_SLOT_F    = SLOT_FAST_US * TICKS_PER_US;
  localparam int CW          = $clog2(T_RST_LONG + T_LOW_N + T_GAP_N + 1);

  logic line_q, fall, rise, settled_high;
  logic fast_mode;
  logic pres_busy, pres_pd_n;
  logic slot_pd_n;

  swire_line_sync #(
    .STAGES(SYNC_STAGES)
  ) sync_i (
    .clk          (clk),
    .rst          (rst),
    .bus_in       (bus_in),
    .line_q       (line_q),
    .fall         (fall),
    .rise         (rise),
    .settled_high (settled_high)
  );

  swire_reset_det #(
    .CW     (CW),
    .T_LONG (T_RST_LONG),
    .T_FAST (T_RST_FAST)
  ) rdet_i (
    .clk       (clk),
    .rst       (rst),
    .line_q    (line_q),
    .fall      (fall),
    .rise      (rise),
    .ignore    (pres_busy),
    .fast_go   (fast_go),
    .rst_det   (rst_det),
    .fast_mode (fast_mode)
  );

  swire_presence #(
    .CW      (CW),
    .T_GAP_N (T_GAP_N),
    .T_GAP_F (T_GAP_F),
    .T_LOW_N (T_LOW_N),
    .T_LOW_F (T_LOW_F)
  ) pres_i (
    .clk          (clk),
    .rst          (rst),
    .start        (rst_det),
    .fast_mode    (fast_mode),
    .settled_high (settled_high),
    .pd_n         (pres_pd_n),
    .busy         (pres_busy)
  );

  swire_slot #(
    .CW       (CW),
    .T_SLOT_N (T_SLOT_N),
    .T_SLOT_F (T_SLOT_F)
  ) slot_i (
    .clk       (clk),
    .rst       (rst),
    .line_q    (line_q),
    .fall      (fall),
    .block     (pres_busy),
    .fast_mode (fast_mode),
    .tx_en     (tx_en),
    .tx_bit    (tx_bit),
    .pd_n      (slot_pd_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_bit),
    .tx_take   (tx_take)
  );

  // both requesters are flops; the open-drain wire-AND is done here
  assign bus_pd_n = slot_pd_n & pres_pd_n;

  AST_QUIET_IN_PRES: assert property (@(posedge clk) disable iff (rst)
    pres_busy |-> (!rx_valid && !tx_take)); // R11

endmodule

// File: tb/swire_slave_bit_tb_top.sv
module swire_slave_bit_tb_top;

  localparam int TPU    = 2;
  localparam int T_LONG = 480 * TPU;
  localparam int T_FRST = 48 * TPU;
  localparam int GAP_N  = 30 * TPU;
  localparam int GAP_F  = 3 * TPU;
  localparam int LOW_N  = 120 * TPU;
  localparam int LOW_F  = 12 * TPU;
  localparam int SLT_N  = 30 * TPU;
  localparam int SLT_F  = 3 * TPU;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_low = 1'b0;
  logic fast_go = 1'b0;
  logic tx_en = 1'b0;
  logic tx_bit = 1'b1;
  logic bus_pd_n, tx_take, rx_valid, rx_bit, rst_det;
  logic bus_line;

  assign bus_line = bus_pd_n & ~m_low;

  always #5 clk = ~clk;

  swire_slave_bit #(.TICKS_PER_US(TPU)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .bus_in   (bus_line),
    .bus_pd_n (bus_pd_n),
    .fast_go  (fast_go),
    .tx_en    (tx_en),
    .tx_bit   (tx_bit),
    .tx_take  (tx_take),
    .rx_valid (rx_valid),
    .rx_bit   (rx_bit),
    .rst_det  (rst_det)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_rst = 0, n_rx = 0, n_take = 0, n_pdf = 0;
  int c_rst = 0, c_rx = 0, c_take = 0, c_pdf = 0, c_pdr = 0;
  int v_rx = 0;
  logic pd_prev = 1'b1;

  // event monitor, samples at the falling clock edge
  always @(negedge clk) begin
    if (rst_det) begin n_rst++; c_rst = cyc; end
    if (rx_valid) begin n_rx++; c_rx = cyc; v_rx = int'(rx_bit); end
    if (tx_take) begin n_take++; c_take = cyc; end
    if (pd_prev && !bus_pd_n) begin n_pdf++; c_pdf = cyc; end
    if (!pd_prev && bus_pd_n) c_pdr = cyc;
    pd_prev = bus_pd_n;
  end

  int n_chk = 0, n_err = 0;
  int t0 = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse(input int len);
    step();
    t0 = cyc;
    m_low = 1'b1;
    repeat (len) step();
    m_low = 1'b0;
  endtask

  // low pulse that may or may not be a reset; checks presence timing
  task automatic rst_pulse(input int len, input bit exp_rst, input bit fast_after, input string rq);
    int r0, f0, x0, k0, gap, low;
    gap = fast_after ? GAP_F : GAP_N;
    low = fast_after ? LOW_F : LOW_N;
    r0 = n_rst;
    pulse(len);
    f0 = n_pdf; x0 = n_rx; k0 = n_take;
    repeat (GAP_N + LOW_N + 20) step();
    chk((n_rst - r0) == (exp_rst ? 1 : 0), {rq, " reset count"}, n_rst - r0, exp_rst ? 1 : 0);
    if (exp_rst) begin
      chk(c_rst == t0 + 3 + len, {rq, " R2 rst_det cycle"}, c_rst - t0, 3 + len);
      chk(c_pdf == c_rst + 1 + gap, "R4 presence start", c_pdf - c_rst, 1 + gap);
      chk(c_pdr - c_pdf == low, "R4 presence length", c_pdr - c_pdf, low);
      chk(n_rx == x0 && n_take == k0, "R11 quiet during presence",
          (n_rx - x0) + (n_take - k0), 0);
    end else begin
      chk(n_pdf == f0, {rq, " no presence"}, n_pdf - f0, 0);
    end
  endtask

  task automatic write_slot(input int len, input int tim, input string rq);
    int x0, ex;
    ex = (len >= tim + 1) ? 0 : 1;
    x0 = n_rx;
    pulse(len);
    repeat (tim + 12) step();
    chk(n_rx - x0 == 1, {rq, " rx count"}, n_rx - x0, 1);
    chk(c_rx == t0 + 3 + tim, {rq, " rx cycle"}, c_rx - t0, 3 + tim);
    chk(v_rx == ex, {rq, " rx value"}, v_rx, ex);
  endtask

  task automatic read_slot(input bit b, input int tim, input string rq);
    int x0, k0, f0;
    x0 = n_rx; k0 = n_take; f0 = n_pdf;
    tx_en = 1'b1; tx_bit = b;
    pulse(2);
    repeat (tim + 12) step();
    tx_en = 1'b0; tx_bit = 1'b1;
    chk(n_take - k0 == 1 && c_take == t0 + 3, {rq, " R9 take"}, c_take - t0, 3);
    chk(n_rx == x0, {rq, " R9 no rx"}, n_rx - x0, 0);
    if (!b) begin
      chk(n_pdf - f0 == 1 && c_pdf == t0 + 3, {rq, " R9 drive start"}, c_pdf - t0, 3);
      chk(c_pdr - c_pdf == tim, {rq, " R9 drive length"}, c_pdr - c_pdf, tim);
    end else begin
      chk(n_pdf == f0, {rq, " R9 released"}, n_pdf - f0, 0);
    end
  endtask

  initial begin
    repeat (4) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk(bus_pd_n == 1'b1, "R1 pulldown idle", int'(bus_pd_n), 1);
    chk(!rx_valid && !rst_det && !tx_take, "R1 strobes low",
        int'(rx_valid) + int'(rst_det) + int'(tx_take), 0);
    repeat (5) step();

    // R3 normal-speed short pulses
    rst_pulse(T_LONG - 1, 1'b0, 1'b0, "R3 just short");
    rst_pulse(T_FRST, 1'b0, 1'b0, "R3 fast length at normal");
    // R2 and R4 normal resets
    rst_pulse(T_LONG, 1'b1, 1'b0, "R2 at threshold");
    rst_pulse(T_LONG + 9, 1'b1, 1'b0, "R2 longer");

    // R8 write slots at normal speed around the sample point
    write_slot(1, SLT_N, "R8 normal");
    write_slot(2, SLT_N, "R8 normal");
    for (int l = SLT_N - 2; l <= SLT_N + 2; l++) write_slot(l, SLT_N, "R8 normal");
    read_slot(1'b0, SLT_N, "normal 0");
    read_slot(1'b1, SLT_N, "normal 1");

    // R5 enter fast speed
    step(); fast_go = 1'b1; step(); fast_go = 1'b0;
    repeat (4) step();
    for (int l = 1; l <= SLT_F + 3; l++) write_slot(l, SLT_F, "R5 R10 fast");
    read_slot(1'b0, SLT_F, "fast 0");
    read_slot(1'b1, SLT_F, "fast 1");

    // R12 short pulse in fast speed is a slot
    rst_pulse(T_FRST - 1, 1'b0, 1'b1, "R12 just short");
    // R6 fast resets keep fast speed
    rst_pulse(T_FRST, 1'b1, 1'b1, "R6 at threshold");
    tx_en = 1'b1; tx_bit = 1'b0;
    rst_pulse(80 * TPU, 1'b1, 1'b1, "R6 80us with read pending");
    tx_en = 1'b0; tx_bit = 1'b1;
    rst_pulse(T_LONG - 1, 1'b1, 1'b1, "R6 just under long");
    write_slot(1, SLT_F, "R6 still fast");

    // R7 long reset drops to normal
    rst_pulse(T_LONG, 1'b1, 1'b0, "R7 long in fast");
    write_slot(1, SLT_N, "R7 normal again");
    write_slot(SLT_N + 1, SLT_N, "R7 normal again");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 200000);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule